// File: doc/BRIEF.md
# Byte Translate Coprocessor Engine

The engine maps a stream of source bytes to result bytes through a 256-entry byte lookup table. A controlling sequencer pulses `start` with an operation length, a mode and (for one mode) a stop byte. The engine then takes the table as sixteen 16-byte beats, waits out a short settle, and examines two source bytes per clock. Source data comes in as 8-byte words on a valid/ready port into a 32-word input buffer. Results leave as 8-byte words on a valid/ready port from a 32-word output buffer.

There are three modes, and they share one datapath. Plain translate writes every translated byte. Translate-and-test writes nothing and halts on the first byte whose table entry is nonzero. Translate-until-stop-byte writes translated bytes and halts just before a source byte equal to the stop byte. Status pins report free input slots, ready output words, busy/done, an ending code, and the position and value that ended a halted operation.

Back-pressure rules: a source word moves when `in_valid` and `in_ready` are both high. `in_ready` falls only when the input buffer holds 32 words. A result word moves when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold. The engine stalls when no source word is buffered, or when a result word is due and the output buffer is full. No byte is lost in either case.

Top module: `xlt_engine`

## Requirements
- R1: After `start`, `tbl_ready` is high only while table beats are being taken. Sixteen 16-byte beats are accepted. Byte lane k of beat j is table entry 16*j+k.
- R2: With beats offered back to back, the first byte pair is examined at the 20th rising edge after the `start` edge. `done` rises one edge after the step that decides the ending, so a translate-and-test hit on byte 0 shows `done` 21 edges after start. `busy` and `done` are never high together.
- R3: In plain translate mode (`mode`=0; the value 3 acts the same), result byte i equals table[source byte i]. It is placed in lane i%8 (bits 8*(i%8)+7:8*(i%8)) of result word i/8. A final partial word is zero-padded. The ending code is 1 (length exhausted), and `done` then implies a nonzero ending code.
- R4: With all source words buffered and the output buffer never full, a plain translate of length L (a multiple of 8) shows `done` 21+L/2 edges after start: two bytes per clock.
- R5: In translate-and-test mode (`mode`=1), no result word is produced. The engine halts at the first byte whose table entry is nonzero, with ending code 2, `hit_pos` set to that byte's index and `hit_val` set to its table entry. If no byte qualifies, the ending code is 1.
- R6: In translate-until-stop-byte mode (`mode`=2), the engine halts before translating the first source byte equal to `stop_byte`. The ending code is 3, `hit_pos` is its index and `hit_val` is the byte. The bytes before it are written as in R3. Without a match the ending code is 1.
- R7: `out_valid` and `out_data` hold while `out_ready` is low. A full output buffer or an empty input buffer stalls the engine without dropping or repeating a byte.
- R8: `in_free` equals 32 minus the source words held. `out_count` equals the result words held. `out_valid` is high exactly when `out_count` is nonzero. After reset these read 32, 0 and 0.
- R9: At completion the input buffer is emptied (`in_free` returns to 32) in the edge on which `done` rises. The result words stay until read.
- R10: When 32 source words are held, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| mode | input | 2 | 0 translate, 1 translate-and-test, 2 until stop byte |
| op_len | input | LEN_W | Operation length in bytes |
| stop_byte | input | 8 | Stop byte for mode 2 |
| tbl_valid | input | 1 | Table beat valid |
| tbl_ready | output | 1 | Table beat accepted |
| tbl_data | input | 8*BEAT_BYTES | Table beat, lane k is entry 16*beat+k |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Input buffer can take a word |
| in_data | input | 8*BUS_BYTES | Source word, lane 0 is the earliest byte |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 8*BUS_BYTES | Result word, lane 0 is the earliest byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, status valid |
| end_code | output | 2 | 0 none, 1 length, 2 nonzero entry, 3 stop byte |
| hit_pos | output | LEN_W | Index of the byte that ended a halt |
| hit_val | output | 8 | Table entry (mode 1) or source byte (mode 2) |
| in_free | output | CW | Free input-buffer words |
| out_count | output | CW | Result words ready to read |

## Verification
Some properties are checked on every cycle: output words hold under back-pressure, a full input buffer refuses words, occupancy stays in range and agrees with `out_valid`, `busy` and `done` exclude each other, and the input buffer is empty on the edge where `done` rises. Other behaviour is shown only by the scenarios: the translated byte values and their lane placement, the exact startup and throughput cycle counts, where each mode halts and what it reports, and the absence of lost bytes when stalls come from both sides.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    MODE_XLATE = 2'd0,
    MODE_TEST  = 2'd1,
    MODE_UNTIL = 2'd2,
    MODE_ALT   = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    END_NONE    = 2'd0,
    END_LEN     = 2'd1,
    END_NONZERO = 2'd2,
    END_STOPB   = 2'd3
  } end_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_WARM, ST_RUN, ST_FLUSH, ST_DONE
  } st_e;
endpackage

// File: rtl/xlt_table.sv
module xlt_table #(
  parameter int BEAT_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [$clog2(256/BEAT_BYTES)-1:0] widx,
  input  logic [BEAT_BYTES*8-1:0]       wdata,
  input  logic [7:0]                    ra0,
  input  logic [7:0]                    ra1,
  output logic [7:0]                    rd0,
  output logic [7:0]                    rd1
);
  logic [7:0] mem [256];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int g = 0; g < BEAT_BYTES; g++) begin
        mem[8'(int'(widx) * BEAT_BYTES + g)] <= wdata[g*8 +: 8];
      end
    end
  end

  // two independent read ports
  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/xlt_fifo.sv
module xlt_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/xlt_step.sv
module xlt_step
  import xlt_pkg::*;
(
  input  xmode_e     mode,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] t0,
  input  logic [7:0] t1,
  input  logic [7:0] stop_b,
  input  logic       two,
  output logic [1:0] used,
  output logic [1:0] wr_n,
  output logic [7:0] w0,
  output logic [7:0] w1,
  output logic       stop,
  output end_e       code,
  output logic       stop_off,
  output logic [7:0] stop_val
);
  always_comb begin
    used     = two ? 2'd2 : 2'd1;
    wr_n     = used;
    w0       = t0;
    w1       = t1;
    stop     = 1'b0;
    code     = END_NONE;
    stop_off = 1'b0;
    stop_val = 8'h00;
    unique case (mode)
      MODE_TEST: begin
        wr_n = 2'd0;
        if (t0 != 8'h00) begin
          stop = 1'b1; code = END_NONZERO; stop_val = t0;
        end else if (two && t1 != 8'h00) begin
          stop = 1'b1; code = END_NONZERO; stop_off = 1'b1; stop_val = t1;
        end
      end
      MODE_UNTIL: begin
        if (b0 == stop_b) begin
          wr_n = 2'd0; stop = 1'b1; code = END_STOPB; stop_val = b0;
        end else if (two && b1 == stop_b) begin
          wr_n = 2'd1; stop = 1'b1; code = END_STOPB; stop_off = 1'b1;
          stop_val = b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xlt_engine.sv
module xlt_engine
  import xlt_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int BUF_BYTES   = 256,
  parameter int BUS_BYTES   = 8,
  parameter int BEAT_BYTES  = 16,
  parameter int STARTUP_CYC = 20,
  localparam int WORDS    = BUF_BYTES / BUS_BYTES,
  localparam int CW       = $clog2(WORDS + 1),
  localparam int BEATS    = 256 / BEAT_BYTES,
  localparam int BW       = $clog2(BEATS),
  localparam int OFW      = $clog2(BUS_BYTES),
  localparam int WARM_CYC = STARTUP_CYC - BEATS - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic [LEN_W-1:0]        op_len,
  input  logic [7:0]              stop_byte,
  input  logic                    tbl_valid,
  output logic                    tbl_ready,
  input  logic [BEAT_BYTES*8-1:0] tbl_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BUS_BYTES*8-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BUS_BYTES*8-1:0]  out_data,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              end_code,
  output logic [LEN_W-1:0]        hit_pos,
  output logic [7:0]              hit_val,
  output logic [CW-1:0]           in_free,
  output logic [CW-1:0]           out_count
);
  localparam int DW = BUS_BYTES * 8;

  st_e              st_q;
  xmode_e           mode_q;
  logic [LEN_W-1:0] len_q, pos_q;
  logic [7:0]       stopb_q;
  logic [OFW-1:0]   off_q, acc_cnt_q;
  logic [DW-1:0]    acc_q, acc_nx;
  logic [BW-1:0]    beat_q;
  logic [7:0]       warm_q;
  end_e             endc_q;
  logic [LEN_W-1:0] hpos_q;
  logic [7:0]       hval_q;

  // input buffer
  logic          in_full, in_empty, in_pop, in_clr;
  logic [DW-1:0] in_head;
  logic [CW-1:0] in_cnt;

  xlt_fifo #(.W(DW), .DEPTH(WORDS)) u_in_buf (
    .clk(clk), .rst_n(rst_n), .clr(in_clr),
    .push(in_valid), .wdata(in_data),
    .pop(in_pop), .rdata(in_head),
    .count(in_cnt), .full(in_full), .empty(in_empty)
  );

  // output buffer
  logic          out_full, out_empty, out_push;
  logic [DW-1:0] out_wdata;

  xlt_fifo #(.W(DW), .DEPTH(WORDS)) u_out_buf (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .push(out_push), .wdata(out_wdata),
    .pop(out_ready), .rdata(out_data),
    .count(out_count), .full(out_full), .empty(out_empty)
  );

  // byte pair selection from the head source word
  logic [OFW-1:0] off1;
  logic [7:0]     b0, b1, t0, t1;
  assign off1 = off_q | OFW'(1);
  assign b0   = in_head[{off_q, 3'b000} +: 8];
  assign b1   = in_head[{off1, 3'b000} +: 8];

  logic tbl_we;
  assign tbl_we = (st_q == ST_LOAD) && tbl_valid;

  xlt_table #(.BEAT_BYTES(BEAT_BYTES)) u_table (
    .clk(clk), .we(tbl_we), .widx(beat_q), .wdata(tbl_data),
    .ra0(b0), .ra1(b1), .rd0(t0), .rd1(t1)
  );

  logic [LEN_W-1:0] remaining;
  logic             two, rem0;
  assign remaining = len_q - pos_q;
  assign two       = remaining > LEN_W'(1);
  assign rem0      = (remaining == '0);

  logic [1:0] used, wr_n;
  logic [7:0] w0, w1, stop_val;
  logic       stop, stop_off;
  end_e       stop_code;

  xlt_step u_step (
    .mode(mode_q), .b0(b0), .b1(b1), .t0(t0), .t1(t1),
    .stop_b(stopb_q), .two(two), .used(used), .wr_n(wr_n),
    .w0(w0), .w1(w1), .stop(stop), .code(stop_code),
    .stop_off(stop_off), .stop_val(stop_val)
  );

  // result accumulator write
  logic [OFW-1:0] wpos1;
  logic [OFW:0]   acc_sum;
  logic           push_need, step_go, flush_push;
  assign wpos1     = acc_cnt_q + OFW'(1);
  assign acc_sum   = {1'b0, acc_cnt_q} + (OFW+1)'(wr_n);
  assign push_need = (acc_sum == (OFW+1)'(BUS_BYTES));

  always_comb begin
    acc_nx = acc_q;
    if (wr_n != 2'd0) acc_nx[{acc_cnt_q, 3'b000} +: 8] = w0;
    if (wr_n == 2'd2) acc_nx[{wpos1, 3'b000} +: 8]     = w1;
  end

  assign step_go    = (st_q == ST_RUN) && !rem0 && !in_empty
                      && !(push_need && out_full);
  assign flush_push = (st_q == ST_FLUSH) && (acc_cnt_q != '0) && !out_full;
  assign out_push   = (step_go && push_need) || flush_push;
  assign out_wdata  = (st_q == ST_FLUSH) ? acc_q : acc_nx;
  assign in_pop     = step_go && !stop && (off1 == OFW'(BUS_BYTES - 1));
  assign in_clr     = (st_q == ST_FLUSH) && ((acc_cnt_q == '0) || !out_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= MODE_XLATE;
      len_q     <= '0;
      pos_q     <= '0;
      stopb_q   <= '0;
      off_q     <= '0;
      acc_cnt_q <= '0;
      acc_q     <= '0;
      beat_q    <= '0;
      warm_q    <= '0;
      endc_q    <= END_NONE;
      hpos_q    <= '0;
      hval_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st_q      <= ST_LOAD;
            mode_q    <= xmode_e'(mode);
            len_q     <= op_len;
            stopb_q   <= stop_byte;
            pos_q     <= '0;
            off_q     <= '0;
            acc_cnt_q <= '0;
            acc_q     <= '0;
            beat_q    <= '0;
            endc_q    <= END_NONE;
            hpos_q    <= '0;
            hval_q    <= '0;
          end
        end
        ST_LOAD: begin
          if (tbl_valid) begin
            beat_q <= beat_q + BW'(1);
            if (beat_q == BW'(BEATS - 1)) begin
              st_q   <= ST_WARM;
              warm_q <= '0;
            end
          end
        end
        ST_WARM: begin
          if (warm_q == 8'(WARM_CYC - 1)) st_q <= ST_RUN;
          else                             warm_q <= warm_q + 8'd1;
        end
        ST_RUN: begin
          if (rem0) begin
            endc_q <= END_LEN;
            st_q   <= ST_FLUSH;
          end else if (step_go) begin
            if (push_need) begin
              acc_q     <= '0;
              acc_cnt_q <= '0;
            end else begin
              acc_q     <= acc_nx;
              acc_cnt_q <= acc_sum[OFW-1:0];
            end
            if (stop) begin
              endc_q <= stop_code;
              hpos_q <= pos_q + LEN_W'(stop_off);
              hval_q <= stop_val;
              st_q   <= ST_FLUSH;
            end else begin
              pos_q <= pos_q + LEN_W'(used);
              off_q <= off_q + OFW'(2);
            end
          end
        end
        ST_FLUSH: begin
          if (in_clr) begin
            acc_q     <= '0;
            acc_cnt_q <= '0;
            st_q      <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tbl_ready = (st_q == ST_LOAD);
  assign in_ready  = !in_full;
  assign in_free   = CW'(WORDS) - in_cnt;
  assign out_valid = !out_empty;
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done      = (st_q == ST_DONE);
  assign end_code  = endc_q;
  assign hit_pos   = hpos_q;
  assign hit_val   = hval_q;
endmodule

// File: rtl/xlt_engine_chk.sv
module xlt_engine_chk #(
  parameter int LEN_W     = 16,
  parameter int CW        = 6,
  parameter int WORDS     = 32,
  parameter int BUS_BYTES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tbl_ready,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [BUS_BYTES*8-1:0] out_data,
  input logic                   busy,
  input logic                   done,
  input logic [1:0]             end_code,
  input logic [CW-1:0]          in_free,
  input logic [CW-1:0]          out_count
);
  AST_IN_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_free == '0) |-> !in_ready); // R10

  AST_OCCUPANCY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_free <= CW'(WORDS)) && (out_count <= CW'(WORDS))); // R8

  AST_OUT_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (out_count != '0)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_TBL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_ready |-> (busy && !done)); // R1

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2

  AST_DONE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (end_code != 2'd0)); // R3

  AST_DONE_EMPTIES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (in_free == CW'(WORDS))); // R9
endmodule

bind xlt_engine xlt_engine_chk #(
  .LEN_W(LEN_W), .CW(CW), .WORDS(WORDS), .BUS_BYTES(BUS_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_ready(tbl_ready), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .busy(busy), .done(done), .end_code(end_code),
  .in_free(in_free), .out_count(out_count)
);

// File: tb/xlt_engine_bench.sv
module xlt_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [15:0]  op_len = '0;
  logic [7:0]   stop_byte = '0;
  logic         tbl_valid = 1'b0;
  logic         tbl_ready;
  logic [127:0] tbl_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [63:0]  out_data;
  logic         busy, done;
  logic [1:0]   end_code;
  logic [15:0]  hit_pos;
  logic [7:0]   hit_val;
  logic [5:0]   in_free, out_count;

  xlt_engine u_xlt_engine (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0, cyc = 0, start_cyc = 0;
  logic [7:0]  tm [256];
  logic [7:0]  sb [512];
  logic [63:0] expq [64];
  int exp_wr = 0, exp_rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 60000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_table(int kind);
    for (int i = 0; i < 256; i++) begin
      case (kind)
        0: tm[i] = 8'(i * 37 + 11);
        1: tm[i] = (i >= 8'hC8) ? 8'(i ^ 8'h0F) : 8'h00;
        default: tm[i] = ~8'(i);
      endcase
    end
  endtask

  // queue expected result words for bytes [first, first+n)
  task automatic expect_bytes(int first, int n);
    for (int w = 0; w < (n + 7) / 8; w++) begin
      logic [63:0] v = '0;
      for (int b = 0; b < 8; b++)
        if (w * 8 + b < n) v[b*8 +: 8] = tm[sb[first + w*8 + b]];
      expq[exp_wr] = v;
      exp_wr++;
    end
  endtask

  task automatic push_words(int first_word, int n, int gap);
    for (int k = 0; k < n; k++) begin
      bit ok;
      do begin
        @(negedge clk);
        in_valid = 1'b1;
        for (int b = 0; b < 8; b++) in_data[b*8 +: 8] = sb[(first_word + k)*8 + b];
        ok = in_ready;
        @(posedge clk);
      end while (!ok);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  // start pulse, then table beats back to back (R1)
  task automatic start_op(int m, int len, logic [7:0] sbyte);
    @(negedge clk);
    start = 1'b1; mode = 2'(m); op_len = 16'(len); stop_byte = sbyte;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    for (int j = 0; j < 16; j++) begin
      bit ok;
      do begin
        tbl_valid = 1'b1;
        for (int k = 0; k < 16; k++) tbl_data[k*8 +: 8] = tm[j*16 + k];
        ok = tbl_ready;
        @(posedge clk);
        @(negedge clk);
      end while (!ok);
    end
    tbl_valid = 1'b0;
    chk(tbl_ready == 1'b0, "R1", "tbl_ready after 16 beats", tbl_ready, 0);
  endtask

  task automatic wait_done(output int n);
    int lim = 0;
    while (!done && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    n = cyc - start_cyc;
  endtask

  // drain n words; ready pattern 0 = always, 1 = two of three cycles
  task automatic drain(int n, int pat, string req);
    int got = 0, lim = 0;
    bit held = 1'b0;
    logic [63:0] hd = '0;
    while (got < n && lim < 5000) begin
      bit v, r;
      @(negedge clk);
      if (held) chk(out_valid && out_data == hd, "R7", "held word", out_data, hd);
      r = (pat == 0) ? 1'b1 : ((lim % 3) != 0);
      out_ready = r;
      v = out_valid;
      held = v && !r;
      hd = out_data;
      if (v && r) begin
        chk(out_data == expq[exp_rd], req, "result word", out_data, expq[exp_rd]);
        exp_rd++; got++;
      end
      @(posedge clk);
      lim++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == n, req, "words drained", got, n);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_free == 6'd32, "R8", "reset in_free", in_free, 32);
    chk(out_count == 6'd0 && !out_valid, "R8", "reset out_count", out_count, 0);
    chk(!busy && !done && !tbl_ready, "R2", "reset busy/done", {busy, done}, 0);
    chk(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
  endtask

  task automatic t_fill_translate;
    int n;
    set_table(0);
    for (int i = 0; i < 256; i++) sb[i] = 8'(i * 3 + 1);
    push_words(0, 32, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10", "in_ready with 32 words", in_ready, 0);
    chk(in_free == 6'd0, "R8", "in_free full", in_free, 0);
    expect_bytes(0, 256);
    start_op(0, 256, 8'h00);
    wait_done(n);
    chk(n == 149, "R4", "edges to done for 256 bytes", n, 149);
    chk(end_code == 2'd1, "R3", "end code", end_code, 1);
    chk(out_count == 6'd32, "R8", "out_count", out_count, 32);
    chk(in_free == 6'd32, "R9", "input cleared", in_free, 32);
  endtask

  task automatic t_output_full_stall;
    int n;
    for (int i = 256; i < 272; i++) sb[i] = 8'(i * 5);
    push_words(32, 2, 0);
    expect_bytes(256, 16);
    start_op(0, 16, 8'h00);
    repeat (40) @(negedge clk);
    chk(busy && !done, "R7", "stalled on full output", {busy, done}, 2);
    chk(out_count == 6'd32, "R7", "output still full", out_count, 32);
    drain(34, 0, "R7");
    wait_done(n);
    chk(end_code == 2'd1, "R3", "end code after stall", end_code, 1);
  endtask

  task automatic t_test_first;
    int n;
    set_table(1);
    for (int i = 0; i < 8; i++) sb[i] = 8'(i + 1);
    sb[0] = 8'hD0;
    push_words(0, 1, 0);
    start_op(1, 8, 8'h00);
    wait_done(n);
    chk(n == 21, "R2", "edges to done on first-byte hit", n, 21);
    chk(end_code == 2'd2, "R5", "end code", end_code, 2);
    chk(hit_pos == 16'd0, "R5", "hit_pos", hit_pos, 0);
    chk(hit_val == tm[8'hD0], "R5", "hit_val", hit_val, tm[8'hD0]);
    chk(out_count == 6'd0, "R5", "no output", out_count, 0);
  endtask

  task automatic t_test_mid;
    int n;
    for (int i = 0; i < 40; i++) sb[i] = 8'(i + 2);
    sb[13] = 8'hE1;
    sb[20] = 8'hF0;
    push_words(0, 5, 0);
    start_op(1, 40, 8'h00);
    wait_done(n);
    chk(end_code == 2'd2, "R5", "end code", end_code, 2);
    chk(hit_pos == 16'd13, "R5", "hit_pos odd lane", hit_pos, 13);
    chk(hit_val == tm[8'hE1], "R5", "hit_val", hit_val, tm[8'hE1]);
    chk(out_count == 6'd0, "R5", "no output", out_count, 0);
    chk(in_free == 6'd32, "R9", "leftover words cleared", in_free, 32);
    for (int i = 0; i < 24; i++) sb[i] = 8'(i + 5);
    push_words(0, 3, 1);
    start_op(1, 24, 8'h00);
    wait_done(n);
    chk(end_code == 2'd1, "R5", "no qualifying byte", end_code, 1);
  endtask

  task automatic t_until;
    int n;
    set_table(2);
    for (int i = 0; i < 32; i++) sb[i] = 8'(i ^ 8'hA0);
    sb[11] = 8'h55;
    push_words(0, 4, 0);
    expect_bytes(0, 11);
    start_op(2, 32, 8'h55);
    wait_done(n);
    chk(end_code == 2'd3, "R6", "end code", end_code, 3);
    chk(hit_pos == 16'd11, "R6", "hit_pos", hit_pos, 11);
    chk(hit_val == 8'h55, "R6", "hit_val", hit_val, 8'h55);
    chk(out_count == 6'd2, "R6", "words before stop", out_count, 2);
    drain(2, 0, "R6");
    for (int i = 0; i < 16; i++) sb[i] = 8'(i + 8'h30);
    push_words(0, 2, 0);
    expect_bytes(0, 13);
    start_op(2, 13, 8'h55);
    wait_done(n);
    chk(end_code == 2'd1, "R6", "no stop byte", end_code, 1);
    drain(2, 0, "R3");
  endtask

  task automatic t_backpressure;
    int n;
    set_table(0);
    for (int i = 0; i < 80; i++) sb[i] = 8'(i * 11 + 7);
    expect_bytes(0, 80);
    start_op(0, 80, 8'h00);
    fork
      push_words(0, 10, 2);
      drain(10, 1, "R7");
    join
    wait_done(n);
    chk(end_code == 2'd1, "R3", "end code under stalls", end_code, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_translate();
    t_output_full_stall();
    t_test_first();
    t_test_mid();
    t_until();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule